// File: doc/BRIEF.md
# ATAPI Device Task-File Controller

This block is the device side of a packet-command storage interface. It holds the task-file registers a host sees (error, count, three byte-count bytes, feature, device, status and control) and runs the small command state machine behind them. The host reaches it through a 3-bit register select with 8-bit read and write strobes, plus a 16-bit data write port. A packet command arms the collection of a 12-byte command packet, delivered as six 16-bit data writes. The collected packet then goes to an external decoder through a valid/ready handshake.

The decoder returns a 16-bit result word. The block uses it to set the final status and error values, to fill a ten-byte sense record, and to decide whether to raise the host interrupt. A pending-request flag drives the interrupt line through a disable bit in the control register. Changing that bit therefore takes effect on the line at once, without losing the request. A set-feature command latches the requested transfer class and mode number from the count register. It also raises an interrupt.

Top module: `atapi_taskfile`

## Requirements
- R1: After reset, reads return error 0x01, count 0x01, byte-count low/mid/high 0x81/0x14/0xEB, device 0x00 and status 0x50. The interrupt line, packet-valid and the transfer fields are all 0. The register select codes are 0 error (write: feature), 1 count, 2 byte-count low, 3 byte-count mid, 4 byte-count high, 5 device, 6 status (write: command) and 7 alternate status (write: control).
- R2: Command 0xA0 (packet) enters the command-write state. Status then reads 0x58, count reads 0x01, and error takes bits 1:0 of the feature register.
- R3: In the command-write state, the sixth 16-bit data write sets status to 0xD0 and asserts pkt_valid. Data word k lands in pkt_data[16k+15:16k]. pkt_valid stays high until a cycle with pkt_ready high.
- R4: Data writes outside the command-write state change neither the status nor pkt_valid. The first five writes of a packet leave status at 0x58 and pkt_valid low.
- R5: A nonzero result word sets status to 0x51 and error to (result[3:0] << 4), and it raises the interrupt.
- R6: A zero result word clears status bits 7 (busy) and 0 (check), sets error to 0, and raises no interrupt.
- R7: A status read (select 6) clears the pending interrupt only when status bit 7 is clear. An alternate-status read (select 7) never clears it.
- R8: Control bit 1 masks the interrupt line. Setting it while a request is pending drops the line. Clearing it brings the line back, including for a request raised while it was masked.
- R9: Command 0xEF with feature 0x03 latches count[7:3] on xfer_class and count[2:0] on xfer_num. Command 0xEF raises the interrupt whatever the feature value.
- R10: Any command write clears a pending interrupt, then sets status bits 6 and 4 and clears bit 0. An unknown command code changes nothing else.
- R11: Command 0x08 returns every task-file register, the sense record and pkt_valid to their reset values.
- R12: Any result sets sense byte 0 to 0xF0, byte 2 to result[7:0] and byte 8 to result[15:8], where byte i is sense_data[8i+7:8i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 3 | Task-file register select |
| reg_wr | input | 1 | 8-bit register write strobe |
| reg_rd | input | 1 | 8-bit register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the selected register |
| data_wr | input | 1 | 16-bit data write strobe |
| data_wdata | input | 16 | Data write word |
| pkt_valid | output | 1 | Collected command packet is ready for the decoder |
| pkt_ready | input | 1 | Decoder accepts the packet |
| pkt_data | output | 96 | The 12-byte command packet |
| res_valid | input | 1 | Result word strobe from the decoder |
| res_word | input | 16 | Sense/result word |
| sense_data | output | 80 | Ten-byte sense record |
| xfer_class | output | 5 | Latched transfer-mode class |
| xfer_num | output | 3 | Latched transfer-mode number |
| irq | output | 1 | Host interrupt request |

## Verification
The packet path is exercised with distinct word values in every slot, so a swapped or dropped word shows up in pkt_data. It is also checked partway through, to tell a packet that completes too early from one that completes on time. Results are driven both nonzero and zero, which separates the error path from the clean-completion path in status, error and interrupt behaviour. The interrupt is raised in two conditions, busy and not busy, and then masked and unmasked. Together these distinguish the status-read clear rule from the alternate read, and a true mask from one that discards the request.

// File: rtl/atapi_tf_pkg.sv
// Shared constants and types for the ATAPI task-file controller.
// Assumes a single device per port; all encodings are fixed by the host protocol.
package atapi_tf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMDW = 2'd1,
        ST_BUSY = 2'd2
    } tf_state_e;

    // Register select codes
    localparam logic [2:0] SEL_ERRFEAT = 3'd0;
    localparam logic [2:0] SEL_COUNT   = 3'd1;
    localparam logic [2:0] SEL_BC_LO   = 3'd2;
    localparam logic [2:0] SEL_BC_MID  = 3'd3;
    localparam logic [2:0] SEL_BC_HI   = 3'd4;
    localparam logic [2:0] SEL_DEVICE  = 3'd5;
    localparam logic [2:0] SEL_STATCMD = 3'd6;
    localparam logic [2:0] SEL_ALTCTRL = 3'd7;

    // Command codes
    localparam logic [7:0] OP_RESET   = 8'h08;
    localparam logic [7:0] OP_PACKET  = 8'hA0;
    localparam logic [7:0] OP_SETFEAT = 8'hEF;

    localparam logic [7:0] FEAT_XFER_MODE = 8'h03;

    // Status bits
    localparam logic [7:0] ST_BSY  = 8'h80;
    localparam logic [7:0] ST_DRDY = 8'h40;
    localparam logic [7:0] ST_SERV = 8'h10;
    localparam logic [7:0] ST_DRQ  = 8'h08;
    localparam logic [7:0] ST_CHK  = 8'h01;

    // Reset signature
    localparam logic [7:0] RST_ERROR  = 8'h01;
    localparam logic [7:0] RST_COUNT  = 8'h01;
    localparam logic [7:0] RST_BC_LO  = 8'h81;
    localparam logic [7:0] RST_BC_MID = 8'h14;
    localparam logic [7:0] RST_BC_HI  = 8'hEB;
    localparam logic [7:0] RST_STATUS = 8'h50;

    localparam logic [7:0] CNT_CMD_PHASE = 8'h01;
    localparam logic [7:0] STATUS_FAULT  = 8'h51;

endpackage

// File: rtl/atapi_irq_ctrl.sv
// Interrupt request holder.
// Keeps a pending flag that is set by raise events and cleared by clear events
// (raise wins a tie). The line is the flag gated by the mask bit, so a change of
// the mask takes effect on the line in the same cycle.
module atapi_irq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic clr,
    input  logic mask,
    output logic pending,
    output logic irq
);

    logic pend_q;

    // Pending flag: raise has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (raise)
            pend_q <= 1'b1;
        else if (clr)
            pend_q <= 1'b0;
    end

    assign pending = pend_q;
    assign irq     = pend_q & ~mask;

    // R5
    pend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(raise));

    // R7
    pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !raise) |=> !pend_q);

endmodule

// File: rtl/atapi_pkt_collector.sv
// Command packet collector.
// Gathers PKT_BYTES of packet as data words of WORD_W bits, written in order.
// 'start' rewinds the word index. 'done' pulses with the write that fills the last slot.
// Assumes PKT_BYTES*8 is a multiple of WORD_W.
module atapi_pkt_collector #(
    parameter int PKT_BYTES = 12,
    parameter int WORD_W    = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   wr_en,
    input  logic [WORD_W-1:0]      wdata,
    output logic                   done,
    output logic [PKT_BYTES*8-1:0] pkt_data
);

    localparam int NWORDS = (PKT_BYTES * 8) / WORD_W;
    localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NWORDS - 1);

    logic [IDX_W-1:0] idx_q;

    // Word index: rewinds on start, wraps after the last slot
    always_ff @(posedge clk) begin
        if (!rst_n || start)
            idx_q <= '0;
        else if (wr_en)
            idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
    end

    genvar w;
    generate
        for (w = 0; w < NWORDS; w++) begin : g_slot
            logic [WORD_W-1:0] word_q;
            // Slot storage: captures the write aimed at this slot
            always_ff @(posedge clk) begin
                if (!rst_n)
                    word_q <= '0;
                else if (wr_en && idx_q == IDX_W'(w))
                    word_q <= wdata;
            end
            assign pkt_data[w*WORD_W +: WORD_W] = word_q;
        end
    endgenerate

    assign done = wr_en && (idx_q == LAST);

    // R3
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !start && idx_q != LAST) |=> idx_q == IDX_W'($past(idx_q) + 1'b1));

endmodule

// File: rtl/atapi_sense_store.sv
// Sense record holder.
// Ten bytes by default. On a result load, byte HEAD_IDX gets the fixed header code,
// LO_IDX the low result byte and HI_IDX the high result byte; the rest is kept.
// 'clear' zeroes the whole record.
module atapi_sense_store #(
    parameter int SENSE_BYTES = 10,
    parameter int HEAD_IDX    = 0,
    parameter int LO_IDX      = 2,
    parameter int HI_IDX      = 8,
    parameter logic [7:0] HEAD_CODE = 8'hF0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     load,
    input  logic [15:0]              result,
    output logic [SENSE_BYTES*8-1:0] sense
);

    genvar i;
    generate
        for (i = 0; i < SENSE_BYTES; i++) begin : g_byte
            logic [7:0] b_q;
            logic [7:0] load_val;
            if (i == HEAD_IDX) begin : g_head
                assign load_val = HEAD_CODE;
            end else if (i == LO_IDX) begin : g_lo
                assign load_val = result[7:0];
            end else if (i == HI_IDX) begin : g_hi
                assign load_val = result[15:8];
            end else begin : g_keep
                assign load_val = b_q;
            end
            // Byte register: cleared on reset or clear, reloaded on a result
            always_ff @(posedge clk) begin
                if (!rst_n || clear)
                    b_q <= 8'h00;
                else if (load)
                    b_q <= load_val;
            end
            assign sense[i*8 +: 8] = b_q;
        end
    endgenerate

    // R12
    sense_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clear) |=> sense[HEAD_IDX*8 +: 8] == HEAD_CODE);

endmodule

// File: rtl/atapi_taskfile.sv
// ATAPI device task-file controller (top).
// Holds the host-visible registers and the command state machine. It collects the
// command packet, hands it to a decoder by valid/ready, and applies the decoder's
// result word. Assumes one register access per cycle. A result in the same cycle as
// a command write takes priority for status and error.
module atapi_taskfile
    import atapi_tf_pkg::*;
#(
    parameter int PKT_BYTES   = 12,
    parameter int SENSE_BYTES = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2:0]               reg_sel,
    input  logic                     reg_wr,
    input  logic                     reg_rd,
    input  logic [7:0]               reg_wdata,
    output logic [7:0]               reg_rdata,
    input  logic                     data_wr,
    input  logic [15:0]              data_wdata,
    output logic                     pkt_valid,
    input  logic                     pkt_ready,
    output logic [PKT_BYTES*8-1:0]   pkt_data,
    input  logic                     res_valid,
    input  logic [15:0]              res_word,
    output logic [SENSE_BYTES*8-1:0] sense_data,
    output logic [4:0]               xfer_class,
    output logic [2:0]               xfer_num,
    output logic                     irq
);

    tf_state_e  state_q;
    logic [7:0] err_q, cnt_q, bc_lo_q, bc_mid_q, bc_hi_q, feat_q, dev_q, stat_q, ctrl_q;
    logic       pkt_valid_q;
    logic [4:0] xcls_q;
    logic [2:0] xnum_q;

    logic cmd_wr, cmd_reset, cmd_packet, cmd_setf;
    logic stat_rd, col_wr, col_done, irq_raise, irq_clr, irq_pend;
    logic res_fault;

    assign cmd_wr     = reg_wr && (reg_sel == SEL_STATCMD);
    assign cmd_reset  = cmd_wr && (reg_wdata == OP_RESET);
    assign cmd_packet = cmd_wr && (reg_wdata == OP_PACKET);
    assign cmd_setf   = cmd_wr && (reg_wdata == OP_SETFEAT);
    assign stat_rd    = reg_rd && (reg_sel == SEL_STATCMD);
    assign col_wr     = data_wr && (state_q == ST_CMDW);
    assign res_fault  = res_valid && (res_word != 16'h0000);

    assign irq_raise = cmd_setf || res_fault;
    assign irq_clr   = cmd_wr || (stat_rd && ((stat_q & ST_BSY) == 8'h00));

    atapi_pkt_collector #(
        .PKT_BYTES (PKT_BYTES),
        .WORD_W    (16)
    ) u_collect (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cmd_packet),
        .wr_en    (col_wr),
        .wdata    (data_wdata),
        .done     (col_done),
        .pkt_data (pkt_data)
    );

    atapi_sense_store #(
        .SENSE_BYTES (SENSE_BYTES)
    ) u_sense (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (cmd_reset),
        .load   (res_valid),
        .result (res_word),
        .sense  (sense_data)
    );

    atapi_irq_ctrl u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .raise   (irq_raise),
        .clr     (irq_clr),
        .mask    (ctrl_q[1]),
        .pending (irq_pend),
        .irq     (irq)
    );

    // Control register: host write only, survives the reset command
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= 8'h00;
        else if (reg_wr && reg_sel == SEL_ALTCTRL)
            ctrl_q <= reg_wdata;
    end

    // Transfer-mode latch: set-feature with the transfer-mode subcode
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_reset) begin
            xcls_q <= 5'd0;
            xnum_q <= 3'd0;
        end else if (cmd_setf && feat_q == FEAT_XFER_MODE) begin
            xcls_q <= cnt_q[7:3];
            xnum_q <= cnt_q[2:0];
        end
    end

    // Task-file registers and command state machine
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_reset) begin
            state_q     <= ST_IDLE;
            err_q       <= RST_ERROR;
            cnt_q       <= RST_COUNT;
            bc_lo_q     <= RST_BC_LO;
            bc_mid_q    <= RST_BC_MID;
            bc_hi_q     <= RST_BC_HI;
            feat_q      <= 8'h00;
            dev_q       <= 8'h00;
            stat_q      <= RST_STATUS;
            pkt_valid_q <= 1'b0;
        end else begin
            // plain register writes
            if (reg_wr) begin
                case (reg_sel)
                    SEL_ERRFEAT: feat_q   <= reg_wdata;
                    SEL_COUNT:   cnt_q    <= reg_wdata;
                    SEL_BC_LO:   bc_lo_q  <= reg_wdata;
                    SEL_BC_MID:  bc_mid_q <= reg_wdata;
                    SEL_BC_HI:   bc_hi_q  <= reg_wdata;
                    SEL_DEVICE:  dev_q    <= reg_wdata;
                    default: ;
                endcase
            end
            // decoder handshake
            if (pkt_valid_q && pkt_ready)
                pkt_valid_q <= 1'b0;
            // packet complete
            if (col_done) begin
                state_q     <= ST_BUSY;
                stat_q      <= (stat_q & ~ST_DRQ) | ST_BSY;
                pkt_valid_q <= 1'b1;
            end
            // command handling, then the common status update
            if (cmd_wr) begin
                if (cmd_packet) begin
                    state_q <= ST_CMDW;
                    err_q   <= {6'd0, feat_q[1:0]};
                    cnt_q   <= CNT_CMD_PHASE;
                    stat_q  <= (ST_DRDY | ST_DRQ | ST_DRDY | ST_SERV) & ~ST_CHK;
                end else begin
                    stat_q  <= (stat_q | ST_DRDY | ST_SERV) & ~ST_CHK;
                end
            end
            // decoder result
            if (res_valid) begin
                state_q <= ST_IDLE;
                err_q   <= {res_word[3:0], 4'h0};
                if (res_fault)
                    stat_q <= STATUS_FAULT;
                else
                    stat_q <= stat_q & ~(ST_BSY | ST_CHK);
            end
        end
    end

    // Register read mux
    always_comb begin
        case (reg_sel)
            SEL_ERRFEAT: reg_rdata = err_q;
            SEL_COUNT:   reg_rdata = cnt_q;
            SEL_BC_LO:   reg_rdata = bc_lo_q;
            SEL_BC_MID:  reg_rdata = bc_mid_q;
            SEL_BC_HI:   reg_rdata = bc_hi_q;
            SEL_DEVICE:  reg_rdata = dev_q;
            default:     reg_rdata = stat_q;
        endcase
    end

    assign pkt_valid  = pkt_valid_q;
    assign xfer_class = xcls_q;
    assign xfer_num   = xnum_q;

    // R3
    pkt_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pkt_valid_q) |-> (stat_q & ST_BSY) != 8'h00);

    // R3
    pkt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid_q && !pkt_ready && !cmd_reset) |=> pkt_valid_q);

    // R5
    fault_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_fault && !cmd_reset) |=> (stat_q == STATUS_FAULT && irq_pend));

    // R2
    pkt_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_packet && !res_valid && !data_wr) |=> (stat_q == 8'h58 && state_q == ST_CMDW));

endmodule

// File: tb/atapi_taskfile_test.sv
module atapi_taskfile_test;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        data_wr = 1'b0;
    logic [15:0] data_wdata = 16'h0;
    logic        pkt_valid;
    logic        pkt_ready = 1'b0;
    logic [95:0] pkt_data;
    logic        res_valid = 1'b0;
    logic [15:0] res_word = 16'h0;
    logic [79:0] sense_data;
    logic [4:0]  xfer_class;
    logic [2:0]  xfer_num;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    atapi_taskfile uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_sel    (reg_sel),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .data_wr    (data_wr),
        .data_wdata (data_wdata),
        .pkt_valid  (pkt_valid),
        .pkt_ready  (pkt_ready),
        .pkt_data   (pkt_data),
        .res_valid  (res_valid),
        .res_word   (res_word),
        .sense_data (sense_data),
        .xfer_class (xfer_class),
        .xfer_num   (xfer_num),
        .irq        (irq)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] s, input logic [7:0] v);
        @(negedge clk);
        reg_sel = s; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // read with strobe (side effects apply at the following edge)
    task automatic rd_reg(input logic [2:0] s, output logic [7:0] v);
        @(negedge clk);
        reg_sel = s; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // look at a register without a read strobe
    task automatic peek(input logic [2:0] s, output logic [7:0] v);
        reg_sel = s;
        #1 v = reg_rdata;
    endtask

    task automatic wr_data(input logic [15:0] v);
        @(negedge clk);
        data_wdata = v; data_wr = 1'b1;
        @(negedge clk);
        data_wr = 1'b0;
    endtask

    task automatic give_result(input logic [15:0] v);
        @(negedge clk);
        res_word = v; res_valid = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic ack_packet();
        @(negedge clk);
        pkt_ready = 1'b1;
        @(negedge clk);
        pkt_ready = 1'b0;
    endtask

    function automatic logic [15:0] pword(input int k);
        return 16'hA100 + 16'(k * 16'h0111);
    endfunction

    task automatic t_reset_values();
        logic [7:0] v;
        peek(3'd0, v); check("R1", "error", v, 8'h01);
        peek(3'd1, v); check("R1", "count", v, 8'h01);
        peek(3'd2, v); check("R1", "bc low", v, 8'h81);
        peek(3'd3, v); check("R1", "bc mid", v, 8'h14);
        peek(3'd4, v); check("R1", "bc high", v, 8'hEB);
        peek(3'd5, v); check("R1", "device", v, 8'h00);
        peek(3'd6, v); check("R1", "status", v, 8'h50);
        check("R1", "irq", irq, 0);
        check("R1", "pkt_valid", pkt_valid, 0);
        check("R1", "xfer", {xfer_class, xfer_num}, 0);
    endtask

    task automatic t_packet_cmd();
        logic [7:0] v;
        wr_reg(3'd0, 8'h07);
        wr_reg(3'd6, 8'hA0);
        peek(3'd6, v); check("R2", "status", v, 8'h58);
        peek(3'd1, v); check("R2", "count", v, 8'h01);
        peek(3'd0, v); check("R2", "error", v, 8'h03);
        check("R2", "irq", irq, 0);
    endtask

    task automatic t_collect();
        logic [7:0] v;
        for (int k = 0; k < 5; k++) wr_data(pword(k));
        peek(3'd6, v); check("R4", "status after five", v, 8'h58);
        check("R4", "pkt_valid after five", pkt_valid, 0);
        wr_data(pword(5));
        peek(3'd6, v); check("R3", "status at end", v, 8'hD0);
        check("R3", "pkt_valid", pkt_valid, 1);
        for (int k = 0; k < 6; k++) check("R3", "packet word", pkt_data[16*k +: 16], pword(k));
        repeat (3) @(negedge clk);
        check("R3", "pkt_valid held", pkt_valid, 1);
        wr_data(16'hDEAD);
        peek(3'd6, v); check("R4", "status busy write", v, 8'hD0);
        check("R4", "word 0 kept", pkt_data[15:0], pword(0));
        ack_packet();
        check("R3", "pkt_valid after ack", pkt_valid, 0);
    endtask

    task automatic t_result_fault();
        logic [7:0] v;
        give_result(16'h0205);
        peek(3'd6, v); check("R5", "status", v, 8'h51);
        peek(3'd0, v); check("R5", "error", v, 8'h50);
        check("R5", "irq", irq, 1);
        check("R12", "sense 0", sense_data[7:0], 8'hF0);
        check("R12", "sense 2", sense_data[23:16], 8'h05);
        check("R12", "sense 8", sense_data[71:64], 8'h02);
        check("R12", "sense 1", sense_data[15:8], 8'h00);
    endtask

    task automatic t_mask();
        wr_reg(3'd7, 8'h02);
        check("R8", "masked line", irq, 0);
        wr_reg(3'd7, 8'h00);
        check("R8", "unmasked line", irq, 1);
    endtask

    task automatic t_unknown_cmd();
        logic [7:0] v;
        wr_reg(3'd6, 8'h55);
        peek(3'd6, v); check("R10", "status", v, 8'h50);
        peek(3'd0, v); check("R10", "error kept", v, 8'h50);
        peek(3'd1, v); check("R10", "count kept", v, 8'h01);
        check("R10", "irq cleared", irq, 0);
    endtask

    task automatic t_status_read();
        logic [7:0] v;
        wr_reg(3'd6, 8'hA0);
        for (int k = 0; k < 6; k++) wr_data(16'h0100 + 16'(k));
        ack_packet();
        wr_reg(3'd6, 8'hEF);
        check("R9", "irq raised in busy", irq, 1);
        rd_reg(3'd6, v); check("R7", "status busy", v, 8'hD0);
        check("R7", "irq kept while busy", irq, 1);
        give_result(16'h0000);
        peek(3'd6, v); check("R6", "status", v, 8'h50);
        peek(3'd0, v); check("R6", "error", v, 8'h00);
        check("R6", "irq not raised anew", irq, 1);
        check("R12", "sense 2 zero", sense_data[23:16], 8'h00);
        rd_reg(3'd7, v); check("R7", "alt status", v, 8'h50);
        check("R7", "irq after alt read", irq, 1);
        rd_reg(3'd6, v);
        check("R7", "irq after status read", irq, 0);
    endtask

    task automatic t_setfeature();
        logic [7:0] v;
        wr_reg(3'd1, 8'h0C);
        wr_reg(3'd0, 8'h03);
        wr_reg(3'd6, 8'hEF);
        check("R9", "xfer_class", xfer_class, 5'd1);
        check("R9", "xfer_num", xfer_num, 3'd4);
        check("R9", "irq", irq, 1);
        peek(3'd6, v); check("R10", "status", v, 8'h50);
        rd_reg(3'd6, v);
        wr_reg(3'd7, 8'h02);
        wr_reg(3'd1, 8'h2B);
        wr_reg(3'd0, 8'h11);
        wr_reg(3'd6, 8'hEF);
        check("R9", "other feature keeps class", xfer_class, 5'd1);
        check("R8", "masked raise", irq, 0);
        wr_reg(3'd7, 8'h00);
        check("R8", "raise seen on unmask", irq, 1);
    endtask

    task automatic t_idle_data();
        logic [7:0] v;
        rd_reg(3'd6, v);
        wr_data(16'hBEEF);
        peek(3'd6, v); check("R4", "status idle write", v, 8'h50);
        check("R4", "pkt_valid idle write", pkt_valid, 0);
        check("R4", "word 0 idle write", pkt_data[15:0], 16'h0100);
    endtask

    task automatic t_reset_cmd();
        logic [7:0] v;
        wr_reg(3'd2, 8'h12);
        wr_reg(3'd5, 8'hA5);
        give_result(16'h3307);
        wr_reg(3'd6, 8'hA0);
        for (int k = 0; k < 6; k++) wr_data(16'h0200 + 16'(k));
        wr_reg(3'd6, 8'h08);
        peek(3'd2, v); check("R11", "bc low", v, 8'h81);
        peek(3'd5, v); check("R11", "device", v, 8'h00);
        peek(3'd0, v); check("R11", "error", v, 8'h01);
        peek(3'd1, v); check("R11", "count", v, 8'h01);
        peek(3'd6, v); check("R11", "status", v, 8'h50);
        check("R11", "pkt_valid", pkt_valid, 0);
        check("R11", "sense", sense_data, 80'h0);
        check("R11", "irq", irq, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_values();
        t_packet_cmd();
        t_collect();
        t_result_fault();
        t_mask();
        t_unknown_cmd();
        t_status_read();
        t_setfeature();
        t_idle_data();
        t_reset_cmd();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule